// File: doc/BRIEF.md
# Bit-Sliced ALU With Signed Set-Less-Than

This block is a purely combinational 32-bit arithmetic/logic unit for an integer datapath. It is built from one 1-bit cell per bit position. Each cell has an AND gate, an OR gate, an exclusive-OR term, a full adder and a result multiplexer. The top bit position uses its own cell variant. That variant also produces the signed overflow flag and the sign that drives set-less-than. Carries are not rippled bit by bit. Each cell exports a propagate/generate pair into 4-bit lookahead groups, and those groups are chained together.

A 3-bit operation code chooses the result. The high bit of the code inverts operand B at every cell and forces the adder's carry-in to 1. Subtraction and comparison therefore reuse the same adder as addition. For set-less-than, the overflow-corrected sign of a − b is fed back into the "less" input of bit 0, and all other bits return 0. A zero flag, signed overflow and adder carry-out come with every result.

Top module: `alu32_slt`

## Requirements
- R1: Code 3'b000 gives result = opnd_a AND opnd_b.
- R2: Code 3'b001 gives result = opnd_a OR opnd_b.
- R3: Code 3'b011 gives result = opnd_a XOR opnd_b.
- R4: Code 3'b010 gives result = low 32 bits of opnd_a + opnd_b + carry_in, and carry_out = bit 32 of that sum.
- R5: Code 3'b110 gives result = opnd_a − opnd_b (two's complement) whatever carry_in is. carry_out is 1 exactly when opnd_a ≥ opnd_b unsigned.
- R6: Code 3'b111 gives result = 1 when opnd_a < opnd_b as signed 32-bit numbers and 0 otherwise. Bits 31..1 are always 0. The result is correct when the difference overflows, for example 0x80000000 against 0x7FFFFFFF.
- R7: overflow is 1 exactly when the adder's signed sum overflows. The adder computes opnd_a + opnd_b + carry_in for codes with bit 2 clear, and opnd_a + ~opnd_b + 1 for codes with bit 2 set.
- R8: zero is 1 exactly when all 32 result bits are 0.
- R9: Codes 3'b100 and 3'b101 give result = 0. carry_out and overflow still follow the inverted-B adder of R7.
- R10: For the logic codes (R1–R3), carry_out and overflow still report the non-inverted adder opnd_a + opnd_b + carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 3 | Operation code; bit 2 inverts B and forces carry-in to 1 |
| carry_in | input | 1 | Adder carry-in, used when op_code[2] is 0 |
| result | output | 32 | Selected result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the adder |
| carry_out | output | 1 | Carry out of the top bit of the adder |

## Verification
The bench aims at set-less-than between the extreme values 0x80000000 and 0x7FFFFFFF. A design that takes the raw sign of the difference, without the overflow correction, gives the opposite answer there. It also checks carries that travel through every lookahead group, such as 0xFFFFFFFF + 1 and carry_in into an all-ones operand. A wrong group expansion or a broken link between groups shows up as a corrupted sum and a wrong zero flag. Subtraction is driven with carry_in at 0, to catch a design that forgets to force the carry. The unused codes are driven to confirm that they give 0 and that the flags are still computed.

// File: rtl/alu32_pkg.sv
// Shared definitions for the bit-sliced ALU.
// Assumes a 3-bit operation code whose bit 2 selects B inversion.
package alu32_pkg;

    // Which source a bit cell places on its result output.
    typedef enum logic [2:0] {
        PICK_AND  = 3'd0,
        PICK_OR   = 3'd1,
        PICK_SUM  = 3'd2,
        PICK_XOR  = 3'd3,
        PICK_LESS = 3'd4,
        PICK_NONE = 3'd5
    } pick_e;

    localparam logic [2:0] OPC_AND  = 3'b000;
    localparam logic [2:0] OPC_OR   = 3'b001;
    localparam logic [2:0] OPC_ADD  = 3'b010;
    localparam logic [2:0] OPC_XOR  = 3'b011;
    localparam logic [2:0] OPC_SUB  = 3'b110;
    localparam logic [2:0] OPC_SLT  = 3'b111;

endpackage

// File: rtl/alu32_op_decode.sv
// Operation decoder: turns the 3-bit code into the B-invert control,
// the forced carry-in and the result source of every bit cell.
// Assumes: a code with bit 2 set always inverts B and forces carry-in to 1.
module alu32_op_decode
    import alu32_pkg::*;
(
    input  logic [2:0] op_i,
    output logic       invert_b_o,
    output logic       force_cin_o,
    output pick_e      pick_o
);

    assign invert_b_o  = op_i[2];
    assign force_cin_o = op_i[2];

    // Map each code to the source the cells present.
    always_comb begin
        case (op_i)
            OPC_AND: pick_o = PICK_AND;
            OPC_OR:  pick_o = PICK_OR;
            OPC_ADD: pick_o = PICK_SUM;
            OPC_XOR: pick_o = PICK_XOR;
            OPC_SUB: pick_o = PICK_SUM;
            OPC_SLT: pick_o = PICK_LESS;
            default: pick_o = PICK_NONE;
        endcase
    end

endmodule

// File: rtl/alu32_cla_group.sv
// Lookahead carry group: from GW propagate/generate pairs and a group
// carry-in, forms every carry of the group as a flat sum of products,
// so no carry ripples inside the group.
// Assumes GW >= 1; carry_o[0] is the group carry-in, carry_o[GW] its carry-out.
module alu32_cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] prop_i,
    input  logic [GW-1:0] gen_i,
    input  logic          cin_i,
    output logic [GW:0]   carry_o
);

    // Expand c(i+1) = g(i) | p(i)g(i-1) | ... | p(i..0)cin for every bit.
    always_comb begin
        logic term;
        logic chain;
        carry_o[0] = cin_i;
        for (int i = 0; i < GW; i++) begin
            term  = gen_i[i];
            chain = prop_i[i];
            for (int j = i - 1; j >= 0; j--) begin
                term  = term | (chain & gen_i[j]);
                chain = chain & prop_i[j];
            end
            carry_o[i+1] = term | (chain & cin_i);
        end
    end

endmodule

// File: rtl/alu32_bit_slice.sv
// Ordinary 1-bit ALU cell: AND, OR, XOR and full-adder sum of a and the
// optionally inverted b. A multiplexer picks one of them or the "less" input.
// It exports propagate (a|b') and generate (a&b') for the lookahead groups.
// Assumes carry_i comes from the lookahead network, not from a neighbour cell.
module alu32_bit_slice
    import alu32_pkg::*;
(
    input  logic  a_i,
    input  logic  b_i,
    input  logic  invert_b_i,
    input  logic  carry_i,
    input  logic  less_i,
    input  pick_e pick_i,
    output logic  res_o,
    output logic  prop_o,
    output logic  gen_o
);

    logic b_eff;

    assign b_eff  = b_i ^ invert_b_i;
    assign prop_o = a_i | b_eff;
    assign gen_o  = a_i & b_eff;

    // Result multiplexer over the cell's sources.
    always_comb begin
        case (pick_i)
            PICK_AND:  res_o = a_i & b_eff;
            PICK_OR:   res_o = a_i | b_eff;
            PICK_SUM:  res_o = a_i ^ b_eff ^ carry_i;
            PICK_XOR:  res_o = a_i ^ b_eff;
            PICK_LESS: res_o = less_i;
            default:   res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu32_msb_slice.sv
// Top-bit ALU cell: the same sources as the ordinary cell. It also derives
// signed overflow (carry in XOR carry out of this bit) and the
// overflow-corrected sign of the sum, which drives set-less-than.
// Assumes carry_out_i is the lookahead carry out of this bit position.
module alu32_msb_slice
    import alu32_pkg::*;
(
    input  logic  a_i,
    input  logic  b_i,
    input  logic  invert_b_i,
    input  logic  carry_i,
    input  logic  carry_out_i,
    input  logic  less_i,
    input  pick_e pick_i,
    output logic  res_o,
    output logic  prop_o,
    output logic  gen_o,
    output logic  set_o,
    output logic  ovf_o
);

    logic b_eff;
    logic sum_bit;

    assign b_eff   = b_i ^ invert_b_i;
    assign prop_o  = a_i | b_eff;
    assign gen_o   = a_i & b_eff;
    assign sum_bit = a_i ^ b_eff ^ carry_i;
    assign ovf_o   = carry_i ^ carry_out_i;
    assign set_o   = sum_bit ^ ovf_o;

    // Result multiplexer over the cell's sources.
    always_comb begin
        case (pick_i)
            PICK_AND:  res_o = a_i & b_eff;
            PICK_OR:   res_o = a_i | b_eff;
            PICK_SUM:  res_o = sum_bit;
            PICK_XOR:  res_o = a_i ^ b_eff;
            PICK_LESS: res_o = less_i;
            default:   res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu32_slt.sv
// Bit-sliced ALU top: one cell per bit, lookahead carry groups chained
// group to group, set-less-than fed from the top cell back into bit 0,
// and a zero detector on the result.
// Assumes WIDTH is a multiple of GROUP_W and WIDTH >= 2. Purely combinational.
module alu32_slt
    import alu32_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int GROUP_W = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_code,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int NGROUP = WIDTH / GROUP_W;

    logic             invert_b;
    logic             force_cin;
    pick_e            pick;
    logic             cin_eff;
    logic             slt_sign;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] gen_w;
    logic [WIDTH:0]   bit_c;
    logic [NGROUP:0]  grp_c;

    alu32_op_decode u_dec (
        .op_i        (op_code),
        .invert_b_o  (invert_b),
        .force_cin_o (force_cin),
        .pick_o      (pick)
    );

    assign cin_eff      = force_cin ? 1'b1 : carry_in;
    assign grp_c[0]     = cin_eff;
    assign bit_c[WIDTH] = grp_c[NGROUP];

    // Lookahead groups, each taking its carry-in from the group below.
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        logic [GROUP_W:0] cvec;
        alu32_cla_group #(.GW(GROUP_W)) u_grp (
            .prop_i  (prop_w[g*GROUP_W +: GROUP_W]),
            .gen_i   (gen_w[g*GROUP_W +: GROUP_W]),
            .cin_i   (grp_c[g]),
            .carry_o (cvec)
        );
        assign bit_c[g*GROUP_W +: GROUP_W] = cvec[GROUP_W-1:0];
        assign grp_c[g+1] = cvec[GROUP_W];
    end

    // Bit cells; the top position uses the variant with flag logic.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_msb
            alu32_msb_slice u_msb (
                .a_i         (opnd_a[i]),
                .b_i         (opnd_b[i]),
                .invert_b_i  (invert_b),
                .carry_i     (bit_c[i]),
                .carry_out_i (bit_c[i+1]),
                .less_i      (1'b0),
                .pick_i      (pick),
                .res_o       (result[i]),
                .prop_o      (prop_w[i]),
                .gen_o       (gen_w[i]),
                .set_o       (slt_sign),
                .ovf_o       (overflow)
            );
        end else begin : g_std
            alu32_bit_slice u_bit (
                .a_i        (opnd_a[i]),
                .b_i        (opnd_b[i]),
                .invert_b_i (invert_b),
                .carry_i    (bit_c[i]),
                .less_i     ((i == 0) ? slt_sign : 1'b0),
                .pick_i     (pick),
                .res_o      (result[i]),
                .prop_o     (prop_w[i]),
                .gen_o      (gen_w[i])
            );
        end
    end

    assign carry_out = bit_c[WIDTH];
    assign zero      = ~|result;

endmodule

// File: rtl/alu32_slt_chk.sv
// Checker for the bit-sliced ALU: compares the port values against plain
// arithmetic on the operands. Attached to every instance of the top by bind.
module alu32_slt_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_code,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry_out
);

    logic [WIDTH:0]   add_ref;
    logic [WIDTH:0]   sub_ref;
    logic [WIDTH-1:0] b_seen;
    logic [WIDTH:0]   adder_ref;

    // Reference sums and the per-code property checks.
    always_comb begin
        add_ref   = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        sub_ref   = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{WIDTH{1'b0}}, 1'b1};
        b_seen    = op_code[2] ? ~opnd_b : opnd_b;
        adder_ref = op_code[2] ? sub_ref : add_ref;

        if (op_code == 3'b000) begin
            assert_and_R1: assert (result == (opnd_a & opnd_b))
                else $error("R1 AND mismatch");
        end
        if (op_code == 3'b010) begin
            assert_add_R4: assert ({carry_out, result} == add_ref)
                else $error("R4 add mismatch");
        end
        if (op_code == 3'b110) begin
            assert_sub_R5: assert ({carry_out, result} == sub_ref)
                else $error("R5 subtract mismatch");
        end
        if (op_code == 3'b111) begin
            assert_slt_R6: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
                else $error("R6 set-less-than mismatch");
        end
        assert_ovf_R7: assert (overflow == ((opnd_a[WIDTH-1] == b_seen[WIDTH-1]) &&
                                            (adder_ref[WIDTH-1] != opnd_a[WIDTH-1])))
            else $error("R7 overflow mismatch");
        assert_zero_R8: assert (zero == ($countones(result) == 0))
            else $error("R8 zero flag mismatch");
        if (op_code == 3'b100 || op_code == 3'b101) begin
            assert_unused_R9: assert (result == '0 && carry_out == sub_ref[WIDTH])
                else $error("R9 unused code mismatch");
        end
    end

endmodule

bind alu32_slt alu32_slt_chk #(.WIDTH(WIDTH)) chk_i (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .carry_in  (carry_in),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
);

// File: tb/alu32_slt_tb_top.sv
// Directed bench for the bit-sliced ALU: one task per scenario, each
// computing its expected values from the requirements.
module alu32_slt_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  op_code = 3'b000;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        carry_out;

    int checks = 0;
    int errors = 0;

    alu32_slt dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_code   (op_code),
        .carry_in  (carry_in),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one operation and compare all outputs with the requirement model.
    task automatic run(string tag, logic [2:0] op, logic [31:0] a, logic [31:0] b, logic ci);
        logic [31:0] bb;
        logic        c0;
        logic [32:0] s;
        logic [31:0] r;
        logic        ov;
        bb = op[2] ? ~b : b;
        c0 = op[2] ? 1'b1 : ci;
        s  = {1'b0, a} + {1'b0, bb} + {32'd0, c0};
        ov = (a[31] == bb[31]) && (s[31] != a[31]);
        case (op)
            3'b000:  r = a & b;
            3'b001:  r = a | b;
            3'b011:  r = a ^ b;
            3'b010:  r = a + b + {31'd0, ci};
            3'b110:  r = a - b;
            3'b111:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_code = op; carry_in = ci;
        #(CLK_PERIOD/4);
        check(tag, "result", result, r);
        check(tag, "zero", {31'd0, zero}, {31'd0, (r == 32'd0)});
        check(tag, "overflow", {31'd0, overflow}, {31'd0, ov});
        check(tag, "carry_out", {31'd0, carry_out}, {31'd0, s[32]});
    endtask

    task automatic t_reset_state;
        #(CLK_PERIOD/4);
        check("R8 initial", "result", result, 32'd0);
        check("R8 initial", "zero", {31'd0, zero}, 32'd1);
    endtask

    task automatic t_logic_ops;
        run("R1 and", 3'b000, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0);
        run("R1 and disjoint", 3'b000, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        run("R2 or", 3'b001, 32'h8000_0001, 32'h0001_8000, 1'b1);
        run("R3 xor", 3'b011, 32'hDEAD_BEEF, 32'hFFFF_0000, 1'b0);
        run("R3 xor self", 3'b011, 32'h1234_5678, 32'h1234_5678, 1'b0);
    endtask

    task automatic t_add;
        run("R4 add", 3'b010, 32'd100, 32'd23, 1'b0);
        run("R4 add full chain", 3'b010, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run("R4 add carry_in chain", 3'b010, 32'hFFFF_FFFF, 32'd0, 1'b1);
        run("R4 add group edge", 3'h2, 32'h0000_000F, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_sub;
        run("R5 sub", 3'b110, 32'd50, 32'd8, 1'b0);
        run("R5 sub borrow", 3'b110, 32'd3, 32'd5, 1'b0);
        run("R5 sub cin ignored", 3'b110, 32'd7, 32'd7, 1'b0);
        run("R5 sub cin ignored hi", 3'b110, 32'd7, 32'd7, 1'b1);
    endtask

    task automatic t_slt;
        run("R6 slt min vs max", 3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
        run("R6 slt max vs min", 3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
        run("R6 slt neg vs pos", 3'b111, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run("R6 slt equal", 3'b111, 32'd42, 32'd42, 1'b0);
        run("R6 slt small", 3'b111, 32'd3, 32'd9, 1'b1);
    endtask

    task automatic t_overflow;
        run("R7 add pos ovf", 3'b010, 32'h7FFF_FFFF, 32'd1, 1'b0);
        run("R7 add neg ovf", 3'b010, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run("R7 sub ovf", 3'b110, 32'h8000_0000, 32'd1, 1'b0);
    endtask

    task automatic t_unused_codes;
        run("R9 code 100", 3'b100, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0);
        run("R9 code 101", 3'b101, 32'h8000_0000, 32'd1, 1'b1);
    endtask

    task automatic t_logic_flags;
        run("R10 and flags", 3'b000, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run("R10 or flags", 3'b001, 32'h7FFF_FFFF, 32'd0, 1'b1);
        run("R10 xor flags", 3'b011, 32'h8000_0000, 32'h8000_0000, 1'b0);
    endtask

    task automatic t_random;
        logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
        for (int k = 0; k < 300; k++) begin
            run("R4 R5 R6 R7 random", codes[k % 6], $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        t_reset_state();
        t_logic_ops();
        t_add();
        t_sub();
        t_slt();
        t_overflow();
        t_unused_codes();
        t_logic_flags();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule